// File: doc/BRIEF.md
# UART Interrupt Request Generator

This block produces the single interrupt request line of a UART that is controlled over a serial peripheral port. Four event sources are tracked: unread receive data, an emptied transmit buffer, a set parity bit in the oldest received word, and a shared line-event bit. The shared bit reports activity on the receive line while the UART sleeps, and a stop-bit framing fault while it runs. Each source has its own enable bit in a mask register. The request output is active low and asserts while any enabled source is set.

The receive FIFO, the serial framer and the command decoder sit outside this block. They supply level and pulse inputs: FIFO occupancy, the parity bit of the FIFO head, framing pulses, and a strobe for each serial clock rising edge with its ordinal within the current command and the command kind. There is no data stream here, so every pin is a plain control or status signal with no handshake. Status bits are presented on a 4-bit vector so that a command decoder can return them to the host.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, `irq_n` is 1, `status` is 0000 (with `tx_empty` low) and the mask register holds 0000.
- R2: `irq_n` is a register. It goes low one clock after an enabled source is set and returns high one clock after no enabled source remains. Disabled sources never pull it low.
- R3: `status[0]` equals `rx_avail` delayed by one clock. The receive interrupt stays asserted for as long as that bit and mask bit 0 are both 1.
- R4: `status[1]` equals `tx_empty` delayed by one clock. A 0-to-1 change on `tx_empty` sets a separate transmit-pending latch, which drives the interrupt through mask bit 1. The reset state of the edge detector treats the line as already empty.
- R5: The transmit-pending latch clears on a `sclk_rise` strobe whose `sclk_count` is 16 and whose `op_kind` is 2'b10 (write data) or 2'b11 (read data). Other kinds (2'b00, 2'b01) and other counts leave it set. A new empty edge in the same cycle wins over the clear. `status[1]` is unaffected by the clear.
- R6: `status[2]` is `parity_en & head_parity` delayed by one clock. It tracks whatever word is at the FIFO head, and it raises the interrupt through mask bit 2.
- R7: While `shutdown` is high, `status[3]` shows the activity latch. That latch sets on any level change of `rx_line` after a two-flop synchronizer, and it is forced to 0 whenever `shutdown` is low.
- R8: While `shutdown` is low, `status[3]` shows the framing latch. `frame_bad` sets the latch and `frame_good` clears it, and `frame_bad` wins if both arrive together. Mask bit 3 enables this source in either mode.
- R9: The bits of `status` and of the mask are ordered receive data (bit 0), transmit empty (bit 1), parity (bit 2), line event (bit 3).
- R10: A high `mask_we` loads `mask_in` into the mask register at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_avail | input | 1 | Receive FIFO holds unread data |
| head_parity | input | 1 | Parity bit of the oldest FIFO word |
| parity_en | input | 1 | Parity checking enabled |
| shutdown | input | 1 | UART is in low-power shutdown |
| rx_line | input | 1 | Raw asynchronous receive line |
| frame_bad | input | 1 | Pulse: zero sampled at the first stop bit |
| frame_good | input | 1 | Pulse: a correctly framed character arrived |
| tx_empty | input | 1 | Transmit buffer is empty |
| sclk_rise | input | 1 | One-cycle strobe per serial clock rising edge |
| sclk_count | input | 5 | Ordinal of that edge within the command, from 1 |
| op_kind | input | 2 | Command kind: 00 idle, 01 config, 10 write data, 11 read data |
| mask_we | input | 1 | Load strobe for the mask register |
| mask_in | input | 4 | New mask value |
| irq_n | output | 1 | Interrupt request, active low |
| status | output | 4 | Source status bits |

## Verification
The hardest case to reach is the transmit-pending clear. The latch must be set by an empty edge and then be shown to survive commands of the wrong kind and commands that stop short of sixteen edges. Only after that can it be shown to fall on the sixteenth edge of a data command, while `status[1]` keeps reading 1. The stimulus generates full strobe trains with counted ordinals for each command kind and checks `irq_n` after each train. The line-event bit needs a similar sequence: the bench enters shutdown, waits out the synchronizer, toggles `rx_line`, and then leaves shutdown to show the bit clears and switches back to framing status.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int SRC_N   = 4;
  localparam int SRC_RX  = 0;
  localparam int SRC_TX  = 1;
  localparam int SRC_PAR = 2;
  localparam int SRC_EVT = 3;

  typedef enum logic [1:0] {
    OP_IDLE    = 2'b00,
    OP_CFG     = 2'b01,
    OP_WR_DATA = 2'b10,
    OP_RD_DATA = 2'b11
  } spi_op_e;
endpackage

// File: rtl/irq_rx_activity.sv
module irq_rx_activity #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_line,
  input  logic shutdown,
  output logic act_q
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] chain;
  logic                   prev_q;
  logic                   toggled;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b1;
        else     chain[i] <= rx_line;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b1;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= chain[LAST];
  end

  assign toggled = chain[LAST] ^ prev_q;

  always_ff @(posedge clk) begin
    if (rst || !shutdown) act_q <= 1'b0;
    else if (toggled)     act_q <= 1'b1;
  end
endmodule

// File: rtl/irq_tx_empty.sv
module irq_tx_empty
  import uart_irq_pkg::*;
#(
  parameter int CNT_W    = 5,
  parameter int CLR_EDGE = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_empty,
  input  logic             sclk_rise,
  input  logic [CNT_W-1:0] sclk_count,
  input  logic [1:0]       op_kind,
  output logic             t_stat,
  output logic             t_pend
);
  localparam logic [CNT_W-1:0] CLR_VAL = CNT_W'(CLR_EDGE);

  logic    empty_d;
  logic    empty_rise;
  logic    data_op;
  logic    clr_hit;
  spi_op_e op;

  assign op         = spi_op_e'(op_kind);
  assign data_op    = (op == OP_WR_DATA) || (op == OP_RD_DATA);
  assign clr_hit    = sclk_rise && (sclk_count == CLR_VAL) && data_op;
  assign empty_rise = tx_empty && !empty_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_d <= 1'b1;
      t_stat  <= 1'b0;
    end else begin
      empty_d <= tx_empty;
      t_stat  <= tx_empty;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             t_pend <= 1'b0;
    else if (empty_rise) t_pend <= 1'b1;
    else if (clr_hit)    t_pend <= 1'b0;
  end
endmodule

// File: rtl/irq_frame_err.sv
module irq_frame_err (
  input  logic clk,
  input  logic rst,
  input  logic frame_bad,
  input  logic frame_good,
  output logic fe_q
);
  always_ff @(posedge clk) begin
    if (rst)             fe_q <= 1'b0;
    else if (frame_bad)  fe_q <= 1'b1;
    else if (frame_good) fe_q <= 1'b0;
  end
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src,
  input  logic         mask_we,
  input  logic [N-1:0] mask_in,
  output logic [N-1:0] mask_q,
  output logic         irq_n
);
  logic [N-1:0] gated;

  for (genvar i = 0; i < N; i++) begin : g_gate
    assign gated[i] = src[i] & mask_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (mask_we) mask_q <= mask_in;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~(|gated);
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 5,
  parameter int CLR_EDGE    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_avail,
  input  logic             head_parity,
  input  logic             parity_en,
  input  logic             shutdown,
  input  logic             rx_line,
  input  logic             frame_bad,
  input  logic             frame_good,
  input  logic             tx_empty,
  input  logic             sclk_rise,
  input  logic [CNT_W-1:0] sclk_count,
  input  logic [1:0]       op_kind,
  input  logic             mask_we,
  input  logic [SRC_N-1:0] mask_in,
  output logic             irq_n,
  output logic [SRC_N-1:0] status
);
  logic             rx_q;
  logic             par_q;
  logic             shut_q;
  logic             ra_q;
  logic             fe_q;
  logic             t_stat;
  logic             t_pend;
  logic             evt_bit;
  logic [SRC_N-1:0] src_vec;
  logic [SRC_N-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q   <= 1'b0;
      par_q  <= 1'b0;
      shut_q <= 1'b0;
    end else begin
      rx_q   <= rx_avail;
      par_q  <= parity_en & head_parity;
      shut_q <= shutdown;
    end
  end

  irq_rx_activity #(.SYNC_STAGES(SYNC_STAGES)) u_act (
    .clk(clk), .rst(rst), .rx_line(rx_line), .shutdown(shutdown), .act_q(ra_q)
  );

  irq_frame_err u_fe (
    .clk(clk), .rst(rst), .frame_bad(frame_bad), .frame_good(frame_good), .fe_q(fe_q)
  );

  irq_tx_empty #(.CNT_W(CNT_W), .CLR_EDGE(CLR_EDGE)) u_tx (
    .clk(clk), .rst(rst), .tx_empty(tx_empty), .sclk_rise(sclk_rise),
    .sclk_count(sclk_count), .op_kind(op_kind), .t_stat(t_stat), .t_pend(t_pend)
  );

  assign evt_bit = shut_q ? ra_q : fe_q;

  always_comb begin
    status          = '0;
    status[SRC_RX]  = rx_q;
    status[SRC_TX]  = t_stat;
    status[SRC_PAR] = par_q;
    status[SRC_EVT] = evt_bit;
    src_vec         = status;
    src_vec[SRC_TX] = t_pend;
  end

  irq_merge #(.N(SRC_N)) u_merge (
    .clk(clk), .rst(rst), .src(src_vec), .mask_we(mask_we),
    .mask_in(mask_in), .mask_q(mask_q), .irq_n(irq_n)
  );
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
  parameter int CNT_W    = 5,
  parameter int CLR_EDGE = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_avail,
  input logic             head_parity,
  input logic             parity_en,
  input logic             shutdown,
  input logic             tx_empty,
  input logic             sclk_rise,
  input logic [CNT_W-1:0] sclk_count,
  input logic [1:0]       op_kind,
  input logic [3:0]       mask_q,
  input logic             t_pend,
  input logic             ra_q,
  input logic             irq_n,
  input logic [3:0]       status
);
  localparam logic [CNT_W-1:0] CLR_VAL = CNT_W'(CLR_EDGE);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (irq_n && mask_q == 4'b0000));

  a_r2_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (mask_q == 4'b0000 && $past(mask_q) == 4'b0000) |-> irq_n);

  a_r3_rx_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status[0] == $past(rx_avail)));

  a_r4_tx_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status[1] == $past(tx_empty)));

  a_r5_pend_clear: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && sclk_count == CLR_VAL && op_kind[1] && !tx_empty) |=> !t_pend);

  a_r6_parity_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status[2] == $past(parity_en & head_parity)));

  a_r7_awake_clear: assert property (@(posedge clk) disable iff (rst)
    !shutdown |=> !ra_q);
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.CNT_W(CNT_W), .CLR_EDGE(CLR_EDGE)) u_chk (
  .clk(clk), .rst(rst), .rx_avail(rx_avail), .head_parity(head_parity),
  .parity_en(parity_en), .shutdown(shutdown), .tx_empty(tx_empty),
  .sclk_rise(sclk_rise), .sclk_count(sclk_count), .op_kind(op_kind),
  .mask_q(mask_q), .t_pend(t_pend), .ra_q(ra_q), .irq_n(irq_n), .status(status)
);

// File: tb/uart_irq_ctrl_bench.sv
module uart_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_avail = 0, head_parity = 0, parity_en = 0, shutdown = 0;
  logic       rx_line = 1, frame_bad = 0, frame_good = 0, tx_empty = 0;
  logic       sclk_rise = 0;
  logic [4:0] sclk_count = '0;
  logic [1:0] op_kind = 2'b00;
  logic       mask_we = 0;
  logic [3:0] mask_in = '0;
  logic       irq_n;
  logic [3:0] status;

  typedef struct {
    logic       irq;
    logic [3:0] st;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  always #4 clk = ~clk;

  uart_irq_ctrl u_uart_irq_ctrl (
    .clk(clk), .rst(rst), .rx_avail(rx_avail), .head_parity(head_parity),
    .parity_en(parity_en), .shutdown(shutdown), .rx_line(rx_line),
    .frame_bad(frame_bad), .frame_good(frame_good), .tx_empty(tx_empty),
    .sclk_rise(sclk_rise), .sclk_count(sclk_count), .op_kind(op_kind),
    .mask_we(mask_we), .mask_in(mask_in), .irq_n(irq_n), .status(status)
  );

  // monitor: pops expected items and compares against the ports
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (irq_n !== e.irq || status !== e.st) begin
        errors++;
        $display("FAIL %s: irq_n=%b status=%b expected irq_n=%b status=%b",
                 e.tag, irq_n, status, e.irq, e.st);
      end
    end
  end

  task automatic expect_out(input logic irq, input logic [3:0] st, input string tag);
    exp_t e;
    repeat (6) @(negedge clk);
    e.irq = irq; e.st = st; e.tag = tag;
    q.push_back(e);
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic set_mask(input logic [3:0] m);
    @(negedge clk); mask_we = 1; mask_in = m;
    @(negedge clk); mask_we = 0;
  endtask

  task automatic spi_op(input logic [1:0] kind, input int n);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk); sclk_rise = 1; sclk_count = 5'(i); op_kind = kind;
      @(negedge clk); sclk_rise = 0;
    end
    op_kind = 2'b00;
  endtask

  task automatic pulse_bad();
    @(negedge clk); frame_bad = 1; @(negedge clk); frame_bad = 0;
  endtask

  task automatic pulse_good();
    @(negedge clk); frame_good = 1; @(negedge clk); frame_good = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    expect_out(1'b1, 4'b0000, "R1 reset idle");

    // R3 / R2: receive data, masked then enabled
    rx_avail = 1;
    expect_out(1'b1, 4'b0001, "R3 R2 rx masked off");
    set_mask(4'b0001);
    expect_out(1'b0, 4'b0001, "R10 R3 rx irq enabled");
    rx_avail = 0;
    expect_out(1'b1, 4'b0000, "R3 rx drained");

    // R6 parity source
    set_mask(4'b0000);
    parity_en = 1; head_parity = 1;
    expect_out(1'b1, 4'b0100, "R6 R9 parity set");
    parity_en = 0;
    expect_out(1'b1, 4'b0000, "R6 parity disabled");
    parity_en = 1; head_parity = 0;
    expect_out(1'b1, 4'b0000, "R6 head parity zero");
    head_parity = 1; set_mask(4'b0100);
    expect_out(1'b0, 4'b0100, "R6 R2 parity irq");
    head_parity = 0;
    expect_out(1'b1, 4'b0000, "R6 head advanced");
    parity_en = 0;

    // R4 / R5 transmit empty
    set_mask(4'b0010);
    tx_empty = 1;
    expect_out(1'b0, 4'b0010, "R4 tx empty edge");
    spi_op(2'b01, 16);
    expect_out(1'b0, 4'b0010, "R5 config op keeps pending");
    spi_op(2'b10, 8);
    expect_out(1'b0, 4'b0010, "R5 short data op keeps pending");
    spi_op(2'b10, 16);
    expect_out(1'b1, 4'b0010, "R5 write data clears irq, status polled");
    tx_empty = 0;
    expect_out(1'b1, 4'b0000, "R4 tx busy");
    tx_empty = 1;
    expect_out(1'b0, 4'b0010, "R4 second empty edge");
    spi_op(2'b11, 16);
    expect_out(1'b1, 4'b0010, "R5 read data clears irq");
    tx_empty = 0;

    // R8 framing
    set_mask(4'b1000);
    pulse_bad();
    expect_out(1'b0, 4'b1000, "R8 R9 frame error");
    pulse_good();
    expect_out(1'b1, 4'b0000, "R8 frame recovered");
    @(negedge clk); frame_bad = 1; frame_good = 1;
    @(negedge clk); frame_bad = 0; frame_good = 0;
    expect_out(1'b0, 4'b1000, "R8 bad wins over good");
    pulse_good();

    // R7 shutdown activity
    shutdown = 1;
    expect_out(1'b1, 4'b0000, "R7 shutdown quiet");
    rx_line = 0;
    expect_out(1'b0, 4'b1000, "R7 rx activity in shutdown");
    shutdown = 0;
    expect_out(1'b1, 4'b0000, "R7 exit clears activity");
    rx_line = 1;
    expect_out(1'b1, 4'b0000, "R7 awake toggle ignored");

    // R2 multiple sources, all enabled
    set_mask(4'b1111);
    rx_avail = 1; tx_empty = 1;
    expect_out(1'b0, 4'b0011, "R2 combined sources");
    set_mask(4'b0000);
    expect_out(1'b1, 4'b0011, "R2 all masked");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule